// File: doc/BRIEF.md
# Start-Triggered Counting State Machine

This block pairs a small three-state controller with a datapath made of a 4-bit counter and two single-bit flags. It idles until a start request is seen. On that request it zeroes the counter and the completion flag, then counts upward once per cycle. On every counting cycle a status flag copies one bit of the counter. Counting stops when two chosen counter bits are both high. The machine then spends one cycle raising the completion flag and returns to idle.

Every operation tied to a state, and every operation guarded by a branch out of that state, takes effect on the same clock edge. Each branch decision looks at register values from before that edge. As a result the counter always finishes one step past the pattern that ended the run: starting from zero it stops at 7 with the status flag high. The controller drives three decoded state lines, exactly one of which is high, so a parent block can watch the sequence.

Top module: `seq_count_asm`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is idle (`st_idle`=1, `st_run`=0, `st_fin`=0) and `cnt_a`, `flag_e` and `flag_f` are all 0.
- R2: In idle with `start`=0 the machine stays idle, and `cnt_a`, `flag_e` and `flag_f` keep their values.
- R3: In idle with `start`=1, the next cycle shows `cnt_a`=0, `flag_f`=0 and the run state, and `flag_e` keeps its value.
- R4: In every run cycle `cnt_a` increases by one, wrapping from 15 to 0.
- R5: In every run cycle `flag_e` loads bit 1 of `cnt_a` (the second-lowest bit) as it was before the edge.
- R6: The run state moves to the finish state when bits 2 and 1 of `cnt_a` were both 1 before the edge, and otherwise stays in run. `start` has no effect in run.
- R7: The finish state sets `flag_f` to 1 and always returns to idle on the next edge, whatever `start` is. `cnt_a` and `flag_e` keep their values.
- R8: Exactly one of `st_idle`, `st_run` and `st_fin` is high in every cycle. The internal state codes are idle=00, run=01, finish=11, and code 10 is never held.
- R9: A run begun from idle spends exactly seven cycles in the run state and ends with `cnt_a`=7, `flag_e`=1 and `flag_f`=1. A second start after completion repeats the same sequence.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled only in idle |
| cnt_a | output | 4 | Counter value; bit 0 is the least significant |
| flag_e | output | 1 | Status flag loaded from counter bit 1 in every run cycle |
| flag_f | output | 1 | Completion flag |
| st_idle | output | 1 | High while the controller is idle |
| st_run | output | 1 | High while the controller is counting |
| st_fin | output | 1 | High during the completion cycle |

## Verification
Two directed runs from idle, one straight after the other, confirm that a run lasts seven cycles and ends at 7/1/1, and that a fresh start clears the counter left at 7 while the status flag keeps its value. Random start patterns with a low duty cycle separate a start taken in idle from one ignored during run and finish. A phase with start held high most of the time tests back-to-back runs and the unconditional return from the finish state. A reset issued in the middle of a run shows that reset overrides counting from any state.

// File: rtl/seq_count_pkg.sv
package seq_count_pkg;

    // Controller state codes; code 2'b10 is left unused
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b11
    } ctl_state_e;

    // Commands from controller to datapath
    typedef struct packed {
        logic clr_a;
        logic clr_f;
        logic inc_a;
        logic ld_e;
        logic set_f;
    } dp_cmd_t;

    // Status bits from datapath to controller
    typedef struct packed {
        logic bit_lo;
        logic bit_hi;
    } dp_stat_t;

    // Decoded state lines
    typedef struct packed {
        logic idle;
        logic run;
        logic fin;
    } st_dec_t;

    function automatic ctl_state_e next_state(ctl_state_e cur, logic go, dp_stat_t s);
        ctl_state_e nx;
        case (cur)
            ST_IDLE: nx = go ? ST_RUN : ST_IDLE;
            ST_RUN:  nx = (s.bit_lo && s.bit_hi) ? ST_FIN : ST_RUN;
            ST_FIN:  nx = ST_IDLE;
            default: nx = ST_IDLE;
        endcase
        return nx;
    endfunction

    function automatic st_dec_t decode(logic [1:0] code);
        st_dec_t d;
        d.idle = (code == 2'b00);
        d.run  = (code == 2'b01);
        d.fin  = (code == 2'b11);
        return d;
    endfunction

    function automatic dp_cmd_t make_cmd(st_dec_t d, logic go);
        dp_cmd_t c;
        c.clr_a = d.idle & go;
        c.clr_f = d.idle & go;
        c.inc_a = d.run;
        c.ld_e  = d.run;
        c.set_f = d.fin;
        return c;
    endfunction

endpackage

// File: rtl/asm_state_dec.sv
module asm_state_dec
    import seq_count_pkg::*;
(
    input  logic [1:0] code,
    output st_dec_t    dec
);
    always_comb dec = decode(code);
endmodule

// File: rtl/asm_ctrl.sv
module asm_ctrl
    import seq_count_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  dp_stat_t stat,
    output dp_cmd_t  cmd,
    output st_dec_t  dec
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    always_comb state_d = next_state(state_q, start, stat);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    asm_state_dec u_dec (
        .code (state_q),
        .dec  (dec)
    );

    always_comb cmd = make_cmd(dec, start);

    // Assertions
    assert_legal_code_R8: assert property (@(posedge clk) disable iff (rst)
        state_q != 2'b10);
    assert_onehot_dec_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot(dec));
    assert_idle_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (dec.idle && !start) |=> dec.idle);
    assert_idle_go_R3: assert property (@(posedge clk) disable iff (rst)
        (dec.idle && start) |=> dec.run);
    assert_run_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (dec.run && stat.bit_lo && stat.bit_hi) |=> dec.fin);
    assert_run_stay_R6: assert property (@(posedge clk) disable iff (rst)
        (dec.run && !(stat.bit_lo && stat.bit_hi)) |=> dec.run);
    assert_fin_return_R7: assert property (@(posedge clk) disable iff (rst)
        dec.fin |=> dec.idle);
endmodule

// File: rtl/asm_dp.sv
module asm_dp
    import seq_count_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LO_IDX = 1,
    parameter int HI_IDX = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_cmd_t          cmd,
    output logic [CNT_W-1:0] a_q,
    output logic             e_q,
    output logic             f_q,
    output dp_stat_t         stat
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            e_q <= 1'b0;
            f_q <= 1'b0;
        end else begin
            if (cmd.clr_a)      a_q <= '0;
            else if (cmd.inc_a) a_q <= a_q + ONE;
            if (cmd.ld_e)       e_q <= a_q[LO_IDX];
            if (cmd.clr_f)      f_q <= 1'b0;
            else if (cmd.set_f) f_q <= 1'b1;
        end
    end

    always_comb begin
        stat.bit_lo = a_q[LO_IDX];
        stat.bit_hi = a_q[HI_IDX];
    end

    // Assertions
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        cmd.inc_a |=> a_q == $past(a_q) + ONE);
    assert_e_copy_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.ld_e |=> e_q == $past(a_q[LO_IDX]));
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_a && cmd.clr_f) |=> (a_q == '0) && !f_q);
    assert_e_keep_R3: assert property (@(posedge clk) disable iff (rst)
        !cmd.ld_e |=> $stable(e_q));
    assert_a_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clr_a && !cmd.inc_a) |=> $stable(a_q));
    assert_f_set_R7: assert property (@(posedge clk) disable iff (rst)
        cmd.set_f |=> f_q);
endmodule

// File: rtl/seq_count_asm.sv
module seq_count_asm
    import seq_count_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LO_IDX = 1,
    parameter int HI_IDX = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] cnt_a,
    output logic             flag_e,
    output logic             flag_f,
    output logic             st_idle,
    output logic             st_run,
    output logic             st_fin
);
    dp_cmd_t  cmd;
    dp_stat_t stat;
    st_dec_t  dec;

    asm_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .stat  (stat),
        .cmd   (cmd),
        .dec   (dec)
    );

    asm_dp #(
        .CNT_W  (CNT_W),
        .LO_IDX (LO_IDX),
        .HI_IDX (HI_IDX)
    ) u_dp (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .a_q  (cnt_a),
        .e_q  (flag_e),
        .f_q  (flag_f),
        .stat (stat)
    );

    assign st_idle = dec.idle;
    assign st_run  = dec.run;
    assign st_fin  = dec.fin;

    // Assertion across the block outputs
    assert_fin_flags_R9: assert property (@(posedge clk) disable iff (rst)
        st_fin |=> flag_f && st_idle);
endmodule

// File: tb/seq_count_asm_test.sv
module seq_count_asm_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [3:0] cnt_a;
    logic flag_e, flag_f, st_idle, st_run, st_fin;

    int total = 0;
    int bad = 0;

    // reference model: 0 idle, 1 run, 2 finish
    int m_st = 0;
    logic [3:0] m_a = 4'd0;
    logic m_e = 1'b0;
    logic m_f = 1'b0;

    always #4 clk = ~clk;

    seq_count_asm uut (
        .clk(clk), .rst(rst), .start(start),
        .cnt_a(cnt_a), .flag_e(flag_e), .flag_f(flag_f),
        .st_idle(st_idle), .st_run(st_run), .st_fin(st_fin)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_state_bits(int st);
        return (st == 0) ? 4 : (st == 1) ? 2 : 1;
    endfunction

    // one clock: drive at negedge, update model at posedge, compare after
    task automatic cyc(logic r, logic s);
        int prev;
        logic go;
        string ra, re, rf, rs;
        @(negedge clk);
        rst = r;
        start = s;
        @(posedge clk);
        prev = m_st;
        go = s;
        if (r) begin
            m_st = 0; m_a = 0; m_e = 0; m_f = 0;
            ra = "R1"; re = "R1"; rf = "R1"; rs = "R1";
        end else if (prev == 0) begin
            if (go) begin
                m_a = 0; m_f = 0; m_st = 1;
                ra = "R3"; re = "R3"; rf = "R3"; rs = "R3";
            end else begin
                ra = "R2"; re = "R2"; rf = "R2"; rs = "R2";
            end
        end else if (prev == 1) begin
            m_st = (m_a[2] && m_a[1]) ? 2 : 1;
            m_e = m_a[1];
            m_a = m_a + 4'd1;
            ra = "R4"; re = "R5"; rf = "R6"; rs = "R6";
        end else begin
            m_f = 1'b1;
            m_st = 0;
            ra = "R7"; re = "R7"; rf = "R7"; rs = "R7";
        end
        #1;
        chk(ra, "cnt_a", cnt_a, m_a);
        chk(re, "flag_e", flag_e, m_e);
        chk(rf, "flag_f", flag_f, m_f);
        chk(rs, "state", {st_idle, st_run, st_fin}, exp_state_bits(m_st));
        chk("R8", "onehot", $countones({st_idle, st_run, st_fin}), 1);
    endtask

    // directed full run from idle (R9)
    task automatic run_once();
        int n = 0;
        cyc(1'b0, 1'b1);
        while (st_run && n < 20) begin
            n++;
            cyc(1'b0, 1'b0);
        end
        chk("R9", "run cycles", n, 7);
        chk("R9", "finish state", st_fin, 1);
        cyc(1'b0, 1'b0);
        chk("R9", "final cnt_a", cnt_a, 7);
        chk("R9", "final flag_e", flag_e, 1);
        chk("R9", "final flag_f", flag_f, 1);
        chk("R9", "back to idle", st_idle, 1);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1 reset state
        repeat (3) cyc(1'b1, 1'b0);
        chk("R1", "idle after reset", st_idle, 1);
        // R2 idle hold
        repeat (3) cyc(1'b0, 1'b0);
        // R9 first run then a second start after completion
        run_once();
        repeat (2) cyc(1'b0, 1'b0);
        run_once();
        // random, low start duty
        for (int i = 0; i < 400; i++) cyc(1'b0, ($urandom % 4) == 0);
        // mid-run reset (R1)
        cyc(1'b0, 1'b1);
        repeat (3) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b1);
        chk("R1", "reset mid-run cnt_a", cnt_a, 0);
        // random, start mostly high
        for (int i = 0; i < 400; i++) cyc(1'b0, ($urandom % 4) != 0);
        // random with occasional resets
        for (int i = 0; i < 200; i++) cyc(($urandom % 50) == 0, ($urandom % 2) == 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule